// File: doc/BRIEF.md
# Page Write Buffer and Protection Controller

This block sits behind the serial command front-end of a small non-volatile byte store. The front-end decodes the serial protocol and hands over events: opening an array write with a start address, opening a status write, each complete received byte, and the chip-select rise. This block gathers array bytes into a 32-byte page buffer whose pointer wraps within the page, then decides at the chip-select rise whether the write may proceed. The write-enable latch, the active-low write-protect pin and a 3-bit protection field all take part in that decision.

An accepted commit starts a self-timed busy window of `CYCLE_LEN` clocks. During that window the buffered bytes are copied into a 2048x8 array one per clock, and any byte whose address is guarded is skipped. A status write instead loads the protection field when the window ends. At the end of every cycle the write-enable latch is cleared. A registered read port gives the front-end access to the array at all times. The front-end is expected to refuse array accesses while `busy` is high.

Top module: `pgwr_guard_ctrl`

## Requirements
- R1: After reset `busy`, `wel` and `prot` are 0, and every array byte reads 0xFF.
- R2: When not busy, a `wel_clr` pulse clears the write-enable latch and a `wel_set` pulse sets it; clear wins over set; while busy both are ignored.
- R3: Array bytes fill the page buffer starting at `arr_addr[4:0]`. Only the low 5 bits advance per byte, the page bits `arr_addr[10:5]` stay fixed, and a byte past offset 31 wraps to offset 0 and overwrites what was buffered there.
- R4: A cycle starts only on a `cs_rise` with `cs_clean`=1, the latch set, `wp_n`=1 and at least one complete byte received. Any other `cs_rise` discards the pending write with no cycle and no change to the array or to `prot`.
- R5: Field encoding of `prot`: 000 guards nothing; 001, 010, 011 and 100 guard 0x000-0x1FF, 0x200-0x3FF, 0x400-0x5FF and 0x600-0x7FF; 101 guards 0x000-0x3FF; 110 guards 0x000-0x01F; 111 guards 0x7E0-0x7FF.
- R6: Bytes at guarded addresses are never modified, and they read back normally.
- R7: If `wp_n` is low during a status-write collection, the status write is cancelled. Once a cycle is running, `wp_n` has no effect on it.
- R8: `wel` is 0 after every completed array or status cycle.
- R9: `busy` rises in the cycle after the accepted `cs_rise` and stays high for exactly `CYCLE_LEN` cycles.
- R10: `rd_data` shows the array byte at `rd_addr` one cycle after `rd_addr` is applied.
- R11: A status cycle loads `prot` from bits [2:0] of the received byte only when the cycle ends; `prot` holds its old value during the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_n | input | 1 | Write-protect pin, low blocks writes |
| wel_set | input | 1 | Pulse: set write-enable latch |
| wel_clr | input | 1 | Pulse: clear write-enable latch |
| arr_open | input | 1 | Pulse: array write begins at arr_addr |
| arr_addr | input | 11 | Start address of array write |
| sts_open | input | 1 | Pulse: status write begins |
| byte_vld | input | 1 | A complete data byte is on byte_data |
| byte_data | input | 8 | Received data byte |
| cs_rise | input | 1 | Pulse: chip select went high |
| cs_clean | input | 1 | Chip select rose on a byte boundary |
| rd_addr | input | 11 | Read address |
| rd_data | output | 8 | Registered read data |
| busy | output | 1 | Self-timed write cycle running |
| wel | output | 1 | Write-enable latch |
| prot | output | 3 | Protection field |

## Verification
Several results are due at different times. The busy flag is due one clock after the edge that samples `cs_rise`. The latch and the protection field settle on the edge that ends the `CYCLE_LEN`-clock window. Read data lags its address by one clock. The bench drives every stimulus at a falling edge and samples at the next falling edge, so a one-register result is seen on the first sample. It counts busy samples until the flag drops and compares that count with `CYCLE_LEN`. It reads array contents back through the read port only after the window has closed, and it checks `prot` once during the window for the hold value and once after the window for the new value.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
    localparam int PROT_W = 3;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ARR_COLLECT,
        PH_STS_COLLECT,
        PH_ARR_BUSY,
        PH_STS_BUSY
    } phase_t;
endpackage

// File: rtl/pgwr_prot_map.sv
module pgwr_prot_map #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 5
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic [pgwr_pkg::PROT_W-1:0] field,
    output logic                       guarded
);
    localparam int PG_BITS = ADDR_W - PAGE_W;

    logic [1:0]         quarter;
    logic [PG_BITS-1:0] page_no;

    assign quarter = addr[ADDR_W-1:ADDR_W-2];
    assign page_no = addr[ADDR_W-1:PAGE_W];

    always_comb begin
        case (field)
            3'd1, 3'd2, 3'd3, 3'd4: guarded = ({1'b0, quarter} == (field - 3'd1));
            3'd5:                   guarded = (addr[ADDR_W-1] == 1'b0);
            3'd6:                   guarded = (page_no == '0);
            3'd7:                   guarded = (page_no == '1);
            default:                guarded = 1'b0;
        endcase
    end
endmodule

// File: rtl/pgwr_page_buf.sv
module pgwr_page_buf #(
    parameter int PAGE_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PAGE_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_vld,
    output logic              any_vld
);
    localparam int DEPTH = 1 << PAGE_W;

    logic [DATA_W-1:0] slot_q [DEPTH];
    logic [DEPTH-1:0]  mask_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
                mask_q[g] <= 1'b0;
            end else if (clr) begin
                mask_q[g] <= 1'b0;
            end else if (wr_en && (wr_idx == PAGE_W'(g))) begin
                slot_q[g] <= wr_data;
                mask_q[g] <= 1'b1;
            end
        end
    end

    assign rd_data = slot_q[rd_idx];
    assign rd_vld  = mask_q[rd_idx];
    assign any_vld = |mask_q;
endmodule

// File: rtl/pgwr_array.sv
module pgwr_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] cell_q [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) cell_q[i] <= '1;
            rdata <= '1;
        end else begin
            if (we) cell_q[waddr] <= wdata;
            rdata <= cell_q[raddr];
        end
    end
endmodule

// File: rtl/pgwr_guard_ctrl.sv
module pgwr_guard_ctrl #(
    parameter int ADDR_W    = 11,
    parameter int PAGE_W    = 5,
    parameter int DATA_W    = 8,
    parameter int CYCLE_LEN = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wp_n,
    input  logic                         wel_set,
    input  logic                         wel_clr,
    input  logic                         arr_open,
    input  logic [ADDR_W-1:0]            arr_addr,
    input  logic                         sts_open,
    input  logic                         byte_vld,
    input  logic [DATA_W-1:0]            byte_data,
    input  logic                         cs_rise,
    input  logic                         cs_clean,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [DATA_W-1:0]            rd_data,
    output logic                         busy,
    output logic                         wel,
    output logic [pgwr_pkg::PROT_W-1:0]  prot
);
    import pgwr_pkg::*;

    localparam int PG_BITS = ADDR_W - PAGE_W;
    localparam int CNT_W   = (CYCLE_LEN > 1) ? $clog2(CYCLE_LEN) : 1;

    typedef struct packed {
        phase_t               phase;
        logic [PG_BITS-1:0]   page;
        logic [PAGE_W-1:0]    ptr;
        logic [PROT_W-1:0]    sts_val;
        logic                 sts_have;
        logic [CNT_W-1:0]     cnt;
        logic [PAGE_W:0]      scan;
        logic                 wel;
        logic [PROT_W-1:0]    prot;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic              buf_clr, buf_we;
    logic [DATA_W-1:0] buf_rd_data;
    logic              buf_rd_vld, buf_any;
    logic              mem_we;
    logic [ADDR_W-1:0] scan_addr;
    logic              scan_guarded;
    logic              last_tick;

    assign scan_addr = {st_q.page, st_q.scan[PAGE_W-1:0]};
    assign last_tick = (st_q.cnt == CNT_W'(CYCLE_LEN - 1));

    pgwr_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (buf_clr),
        .wr_en   (buf_we),
        .wr_idx  (st_q.ptr),
        .wr_data (byte_data),
        .rd_idx  (st_q.scan[PAGE_W-1:0]),
        .rd_data (buf_rd_data),
        .rd_vld  (buf_rd_vld),
        .any_vld (buf_any)
    );

    pgwr_prot_map #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_map (
        .addr    (scan_addr),
        .field   (st_q.prot),
        .guarded (scan_guarded)
    );

    pgwr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (scan_addr),
        .wdata (buf_rd_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    always_comb begin
        st_d    = st_q;
        buf_clr = 1'b0;
        buf_we  = 1'b0;
        mem_we  = 1'b0;

        // latch control while idle or collecting
        if (st_q.phase != PH_ARR_BUSY && st_q.phase != PH_STS_BUSY) begin
            if (wel_clr)      st_d.wel = 1'b0;
            else if (wel_set) st_d.wel = 1'b1;
        end

        case (st_q.phase)
            PH_IDLE: begin
                if (arr_open) begin
                    st_d.phase = PH_ARR_COLLECT;
                    st_d.page  = arr_addr[ADDR_W-1:PAGE_W];
                    st_d.ptr   = arr_addr[PAGE_W-1:0];
                    buf_clr    = 1'b1;
                end else if (sts_open) begin
                    st_d.phase    = PH_STS_COLLECT;
                    st_d.sts_have = 1'b0;
                end
            end
            PH_ARR_COLLECT: begin
                if (cs_rise) begin
                    if (cs_clean && st_q.wel && wp_n && buf_any) begin
                        st_d.phase = PH_ARR_BUSY;
                        st_d.cnt   = '0;
                        st_d.scan  = '0;
                    end else begin
                        st_d.phase = PH_IDLE;
                        buf_clr    = 1'b1;
                    end
                end else if (byte_vld) begin
                    buf_we   = 1'b1;
                    st_d.ptr = st_q.ptr + 1'b1;
                end
            end
            PH_STS_COLLECT: begin
                if (!wp_n) begin
                    st_d.phase = PH_IDLE;
                end else if (cs_rise) begin
                    if (cs_clean && st_q.wel && st_q.sts_have) begin
                        st_d.phase = PH_STS_BUSY;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.phase = PH_IDLE;
                    end
                end else if (byte_vld) begin
                    st_d.sts_val  = byte_data[PROT_W-1:0];
                    st_d.sts_have = 1'b1;
                end
            end
            PH_ARR_BUSY, PH_STS_BUSY: begin
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.phase == PH_ARR_BUSY && !st_q.scan[PAGE_W]) begin
                    mem_we    = buf_rd_vld && !scan_guarded;
                    st_d.scan = st_q.scan + 1'b1;
                end
                if (last_tick) begin
                    st_d.phase = PH_IDLE;
                    st_d.cnt   = '0;
                    st_d.wel   = 1'b0;
                    if (st_q.phase == PH_STS_BUSY) st_d.prot = st_q.sts_val;
                    else                           buf_clr   = 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, page: '0, ptr: '0, sts_val: '0, sts_have: 1'b0,
                      cnt: '0, scan: '0, wel: 1'b0, prot: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.phase == PH_ARR_BUSY) || (st_q.phase == PH_STS_BUSY);
    assign wel  = st_q.wel;
    assign prot = st_q.prot;
endmodule

// File: rtl/pgwr_guard_chk.sv
module pgwr_guard_chk #(
    parameter int CYCLE_LEN = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wel_set,
    input logic       wel_clr,
    input logic       cs_rise,
    input logic       busy,
    input logic       wel,
    input logic [2:0] prot
);
    logic [31:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1;
        else           run_q <= '0;
    end

    assert_busy_after_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_rise));

    assert_busy_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(run_q) == 32'(CYCLE_LEN - 1)));

    assert_wp_no_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (run_q + 1 < 32'(CYCLE_LEN))) |=> busy);

    assert_latch_off_after_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    assert_clear_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wel_clr) |=> !wel);

    assert_set_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wel_set && !wel_clr) |=> wel);

    assert_prot_only_at_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prot) |-> $fell(busy));

    assert_no_start_unlatched_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && !busy && !wel) |=> !busy);
endmodule

bind pgwr_guard_ctrl pgwr_guard_chk #(.CYCLE_LEN(CYCLE_LEN)) u_guard_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wel_set (wel_set),
    .wel_clr (wel_clr),
    .cs_rise (cs_rise),
    .busy    (busy),
    .wel     (wel),
    .prot    (prot)
);

// File: tb/pgwr_guard_ctrl_test.sv
`timescale 1ns/1ps
module pgwr_guard_ctrl_test;
    localparam int CYC = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wp_n = 1'b1, wel_set = 1'b0, wel_clr = 1'b0;
    logic        arr_open = 1'b0, sts_open = 1'b0, byte_vld = 1'b0;
    logic [10:0] arr_addr = '0, rd_addr = '0;
    logic [7:0]  byte_data = '0;
    logic        cs_rise = 1'b0, cs_clean = 1'b0;
    logic [7:0]  rd_data;
    logic        busy, wel;
    logic [2:0]  prot;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_mem [2048];
    logic [2:0] m_prot = 3'd0;
    logic       m_wel = 1'b0;

    always #4 clk = ~clk;

    pgwr_guard_ctrl #(.CYCLE_LEN(CYC)) uut (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .wel_set(wel_set), .wel_clr(wel_clr),
        .arr_open(arr_open), .arr_addr(arr_addr), .sts_open(sts_open),
        .byte_vld(byte_vld), .byte_data(byte_data), .cs_rise(cs_rise),
        .cs_clean(cs_clean), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .wel(wel), .prot(prot)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit guarded(input int a, input logic [2:0] f);
        case (f)
            3'd1: return a <= 'h1FF;
            3'd2: return a >= 'h200 && a <= 'h3FF;
            3'd3: return a >= 'h400 && a <= 'h5FF;
            3'd4: return a >= 'h600;
            3'd5: return a <= 'h3FF;
            3'd6: return a <= 'h01F;
            3'd7: return a >= 'h7E0;
            default: return 1'b0;
        endcase
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic latch_on();
        wel_set = 1'b1; step(); wel_set = 1'b0;
        m_wel = 1'b1;
        chk(wel == 1'b1, "R2 set", wel, 1);
    endtask

    task automatic latch_off();
        wel_clr = 1'b1; wel_set = 1'b1; step(); wel_clr = 1'b0; wel_set = 1'b0;
        m_wel = 1'b0;
        chk(wel == 1'b0, "R2 clear", wel, 0);
    endtask

    task automatic read_range(input int lo, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            rd_addr = 11'((lo + i) % 2048);
            step();
            chk(rd_data == m_mem[(lo + i) % 2048], req, rd_data, m_mem[(lo + i) % 2048]);
        end
    endtask

    task automatic wait_cycle(input bit wp_low, output int n);
        n = 0;
        if (wp_low) wp_n = 1'b0;
        while (busy && n < CYC + 10) begin
            n++;
            step();
        end
        wp_n = 1'b1;
    endtask

    task automatic arr_write(input int addr, input int n, input bit clean,
                             input bit wp_commit, input bit wp_in_busy);
        logic [7:0] bd [32];
        bit         bv [32];
        int         ptr, len;
        bit         go;
        for (int i = 0; i < 32; i++) bv[i] = 1'b0;
        arr_open = 1'b1; arr_addr = 11'(addr); step(); arr_open = 1'b0;
        ptr = addr % 32;
        for (int i = 0; i < n; i++) begin
            byte_data = 8'($urandom);
            byte_vld = 1'b1; step(); byte_vld = 1'b0;
            bd[ptr] = byte_data; bv[ptr] = 1'b1;
            ptr = (ptr + 1) % 32;
        end
        wp_n = wp_commit; cs_rise = 1'b1; cs_clean = clean; step();
        cs_rise = 1'b0; cs_clean = 1'b0; wp_n = 1'b1;
        go = clean && m_wel && wp_commit && (n > 0);
        chk(busy == go, "R4 commit gate", busy, go);
        if (go) begin
            wait_cycle(wp_in_busy, len);
            chk(len == CYC, wp_in_busy ? "R7 wp in busy" : "R9 busy length", len, CYC);
            for (int i = 0; i < 32; i++) begin
                int a;
                a = (addr / 32) * 32 + i;
                if (bv[i] && !guarded(a, m_prot)) m_mem[a] = bd[i];
            end
            m_wel = 1'b0;
            chk(wel == 1'b0, "R8 latch after array", wel, 0);
        end
        read_range((addr / 32) * 32, 32, "R3/R6 page content");
    endtask

    task automatic sts_write(input logic [7:0] d, input bit clean, input bit wp_drop);
        int  len;
        bit  go;
        sts_open = 1'b1; step(); sts_open = 1'b0;
        byte_data = d; byte_vld = 1'b1; step(); byte_vld = 1'b0;
        if (wp_drop) begin wp_n = 1'b0; step(); wp_n = 1'b1; end
        cs_rise = 1'b1; cs_clean = clean; step(); cs_rise = 1'b0; cs_clean = 1'b0;
        go = clean && m_wel && !wp_drop;
        chk(busy == go, wp_drop ? "R7 wp cancels status" : "R4 status gate", busy, go);
        if (go) begin
            chk(prot == m_prot, "R11 hold during cycle", prot, m_prot);
            wait_cycle(1'b0, len);
            chk(len == CYC, "R9 status busy length", len, CYC);
            m_prot = d[2:0];
            m_wel = 1'b0;
            chk(wel == 1'b0, "R8 latch after status", wel, 0);
        end
        chk(prot == m_prot, "R11/R5 prot field", prot, m_prot);
    endtask

    initial begin
        #(8 * 200000);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int a;
        void'($urandom(32'h5EED_0421));
        for (int i = 0; i < 2048; i++) m_mem[i] = 8'hFF;
        repeat (4) step();
        rst_n = 1'b1;
        step();
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(wel == 1'b0, "R1 wel", wel, 0);
        chk(prot == 3'd0, "R1 prot", prot, 0);
        read_range(0, 2048, "R1/R10 erased read");

        // no latch: blocked
        arr_write('h040, 3, 1, 1, 0);
        latch_on();
        latch_off();
        // wrap within page
        latch_on();
        arr_write('h01E, 4, 1, 1, 0);
        // ragged chip-select rise discards
        latch_on();
        arr_write('h100, 2, 0, 1, 0);
        chk(wel == 1'b1, "R4 latch kept on discard", wel, 1);
        // wp low at commit blocks
        arr_write('h120, 2, 1, 0, 0);
        // guard first page, then try to write it
        sts_write(8'hF6, 1, 0);
        latch_on();
        arr_write('h000, 32, 1, 1, 0);
        // status cancelled by wp
        latch_on();
        sts_write(8'h03, 1, 1);
        chk(wel == 1'b1, "R7 latch kept on cancel", wel, 1);
        // guard last page, long wrap into it
        sts_write(8'h07, 1, 0);
        latch_on();
        arr_write('h7F0, 40, 1, 1, 0);
        latch_on();
        sts_write(8'h00, 1, 0);
        // wp dropped during cycle
        latch_on();
        arr_write('h7E5, 40, 1, 1, 1);

        for (int it = 0; it < 60; it++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 6) begin
                if ($urandom_range(0, 9) < 8) latch_on();
                a = $urandom_range(0, 2047);
                arr_write(a, $urandom_range(0, 40), $urandom_range(0, 9) != 0,
                          $urandom_range(0, 9) != 0, $urandom_range(0, 3) == 0);
            end else if (op < 8) begin
                if ($urandom_range(0, 9) < 8) latch_on();
                sts_write(8'($urandom), $urandom_range(0, 9) != 0, $urandom_range(0, 5) == 0);
                for (int k = 0; k < 4; k++) begin
                    a = $urandom_range(0, 2047);
                    chk(guarded(a, m_prot) == guarded(a, prot), "R5 field decode", prot, m_prot);
                end
            end else begin
                latch_off();
            end
        end

        read_range(0, 2048, "R6/R10 final sweep");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule